// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register Interface

This block is the host-side register file of a 48-line general-purpose I/O controller. It sits on an 8-bit parallel bus with a 16-byte address window. Six byte-wide port registers drive open-drain pins, and every line can serve as an input or an output on its own. Writing a 1 to a port bit makes the pin sink current and pull low. Writing a 0 releases the pin, so an external pull-up holds it high and the line can be read as an input. Because the lines are open-drain, a port read always returns the inverted, synchronized pin level.

A control byte holds a 2-bit page number and six per-port write locks. The page number selects which of three stored banks (polarity, enable, identification), or none of them, appears in a three-byte window above the control byte. The port registers, the pending-status byte and the control byte are visible on every page. The pending-status byte summarises the identification bank, one bit per byte.

Reads are combinational from registered state. Writes take effect at the rising clock edge where the write strobe is high.

Top module: `gpio_paged_regs`

## Requirements
- R1: After reset every port register is 0, so `pin_oe` is all zero and every pin is released. The control byte at offset 0x07 and all nine bank bytes also read 0x00.
- R2: A write to offset k (0x00 to 0x05) whose port is unlocked stores the byte in port k. Bit b of that byte drives `pin_oe[8k+b]`, so the least significant byte sits at the lowest offset.
- R3: A read of offset k (0x00 to 0x05) returns the bitwise inverse of `pin_in[8k+7:8k]` as captured by a two-stage synchronizer. A change on `pin_in` becomes visible after the second rising edge.
- R4: Offset 0x07 reads back the last byte written to it. Bits 7:6 are the page number and bits 5:0 are the lock bits, with bit k belonging to port k.
- R5: While lock bit k is 1, writes to port k are ignored and its `pin_oe` byte keeps its value. After the lock is cleared, writes land again.
- R6: Offsets 0x08 to 0x0A address byte 0 to byte 2 of a bank chosen by the page number: page 1 polarity, page 2 enable, page 3 identification. Each bank keeps its own bytes and is read and written only while its page is selected.
- R7: With page 0 selected, offsets 0x08 to 0x0A read 0x00 and writes to them change no bank. Offsets 0x0B to 0x0F always read 0x00.
- R8: The port registers can be written and read at offsets 0x00 to 0x05 whatever page is selected.
- R9: Offset 0x06 reads the same on every page. Bit j is 1 when identification byte j is nonzero, bits 7:3 are 0, and writes to 0x06 are ignored.
- R10: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, qualifies bus_rdata |
| bus_rdata | output | 8 | Read data, combinational |
| pin_oe | output | 48 | 1 = pin sinks current (driven low), 0 = released |
| pin_in | input | 48 | Pin levels from the pads |

## Verification
The hardest states to reach from the ports are the ones where the page selector hides storage. A bank byte written under one page must survive writes to the same offset under page 0 and under the other pages. A write to a locked port must leave its pin drive untouched while its neighbours still accept writes. The stimulus fills all three banks with distinct bytes, then revisits each page and checks each byte. It also writes through page 0 and through offset 0x06 and confirms that nothing moved. Locks are checked by setting a lock together with a nonzero page, then watching `pin_oe` for the locked port and for an unlocked neighbour. The synchronizer latency is checked edge by edge, holding the read strobe while a pin byte changes.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_PORT  = 6;
  localparam int BANK_LEN  = 3;
  localparam int NUM_BANK  = 3;
  localparam int PAGE_W    = 2;
  localparam int LINES     = NUM_PORT * BYTE_W;

  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OFF_WIN  = ADDR_W'(8);

  typedef enum logic [PAGE_W-1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_ID   = 2'd3
  } page_e;

  typedef struct packed {
    logic [PAGE_W-1:0]   page;
    logic [NUM_PORT-1:0] lock;
  } ctrl_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = st2_q;

  // R3: second stage follows the first one cycle later
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (st2_q == $past(st1_q)));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pg_pkg::*;
#(
  parameter int NP = NUM_PORT,
  parameter int W  = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic [NP-1:0] wr_sel,
  input  logic [NP-1:0] lock,
  input  logic [W-1:0]  wdata,
  output logic [NP*W-1:0] q
);
  logic [NP*W-1:0] q_r, q_nx;
  logic [NP-1:0]   en;

  always_comb begin
    q_nx = q_r;
    for (int k = 0; k < NP; k++) begin
      en[k] = wr_sel[k] & ~lock[k];
      if (en[k]) q_nx[k*W +: W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q_r <= '0;
    else if (|en) q_r <= q_nx;
  end

  assign q = q_r;

  for (genvar g = 0; g < NP; g++) begin : g_chk
    // R5: locked port holds its value
    a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_sn)
      (wr_sel[g] && lock[g]) |=> $stable(q_r[g*W +: W]));
    // R2: unlocked write lands in the addressed byte
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_sn)
      (wr_sel[g] && !lock[g]) |=> (q_r[g*W +: W] == $past(wdata)));
  end
endmodule

// File: rtl/gpio_paged_bank.sv
module gpio_paged_bank
  import gpio_pg_pkg::*;
#(
  parameter int NB  = NUM_BANK,
  parameter int LEN = BANK_LEN,
  parameter int W   = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  input  logic [1:0]        idx,
  input  logic [W-1:0]      wdata,
  output logic [NB*LEN*W-1:0] store
);
  localparam int TOT = NB * LEN;

  logic [TOT*W-1:0] st_r, st_nx;
  logic [TOT-1:0]   hit;

  always_comb begin
    st_nx = st_r;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < LEN; i++) begin
        hit[b*LEN+i] = wr && (int'(page) == b + 1) && (int'(idx) == i);
        if (hit[b*LEN+i]) st_nx[(b*LEN+i)*W +: W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_r <= '0;
    else if (|hit) st_r <= st_nx;
  end

  assign store = st_r;

  // R7: page 0 writes reach no bank
  a_r7_page0_inert: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr && page == PG_NONE) |=> $stable(st_r));
  // R6: at most one bank byte written per cycle
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(hit));
endmodule

// File: rtl/gpio_paged_regs.sv
module gpio_paged_regs
  import gpio_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [LINES-1:0]  pin_oe,
  input  logic [LINES-1:0]  pin_in
);
  localparam int BANK_BITS = NUM_BANK * BANK_LEN * BYTE_W;

  logic                  rst_sn;
  logic [LINES-1:0]      pin_s;
  logic [LINES-1:0]      port_q;
  logic [BANK_BITS-1:0]  bank_q;
  logic [NUM_PORT-1:0]   port_wr;
  logic                  win_hit;
  logic                  win_wr;
  logic [1:0]            win_idx;
  ctrl_t                 ctrl_r, ctrl_nx;
  logic                  ctrl_en;
  logic [BYTE_W-1:0]     pend;
  logic [BYTE_W-1:0]     rd_mux;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  gpio_in_sync #(.WIDTH(LINES)) u_sync (
    .clk    (clk),
    .rst_sn (rst_sn),
    .d      (pin_in),
    .q      (pin_s)
  );

  // write decode
  always_comb begin
    for (int k = 0; k < NUM_PORT; k++)
      port_wr[k] = bus_wr && (bus_addr == ADDR_W'(k));
    win_hit = (bus_addr >= OFF_WIN) && (bus_addr < OFF_WIN + ADDR_W'(BANK_LEN));
    win_idx = 2'(bus_addr - OFF_WIN);
    win_wr  = bus_wr && win_hit;
    ctrl_en = bus_wr && (bus_addr == OFF_CTRL);
    ctrl_nx = ctrl_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ctrl_r <= '0;
    else if (ctrl_en) ctrl_r <= ctrl_nx;
  end

  gpio_port_bank u_ports (
    .clk    (clk),
    .rst_sn (rst_sn),
    .wr_sel (port_wr),
    .lock   (ctrl_r.lock),
    .wdata  (bus_wdata),
    .q      (port_q)
  );

  gpio_paged_bank u_banks (
    .clk    (clk),
    .rst_sn (rst_sn),
    .wr     (win_wr),
    .page   (ctrl_r.page),
    .idx    (win_idx),
    .wdata  (bus_wdata),
    .store  (bank_q)
  );

  assign pin_oe = port_q;

  // pending summary: one bit per identification byte
  localparam int ID_BASE = (int'(PG_ID) - 1) * BANK_LEN;
  always_comb begin
    pend = '0;
    for (int j = 0; j < BANK_LEN; j++)
      pend[j] = |bank_q[(ID_BASE + j)*BYTE_W +: BYTE_W];
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (bus_addr < ADDR_W'(NUM_PORT)) begin
      for (int k = 0; k < NUM_PORT; k++)
        if (bus_addr == ADDR_W'(k)) rd_mux = ~pin_s[k*BYTE_W +: BYTE_W];
    end else if (bus_addr == OFF_PEND) begin
      rd_mux = pend;
    end else if (bus_addr == OFF_CTRL) begin
      rd_mux = BYTE_W'(ctrl_r);
    end else if (win_hit && ctrl_r.page != PG_NONE) begin
      for (int b = 0; b < NUM_BANK; b++)
        for (int i = 0; i < BANK_LEN; i++)
          if (int'(ctrl_r.page) == b + 1 && int'(win_idx) == i)
            rd_mux = bank_q[(b*BANK_LEN + i)*BYTE_W +: BYTE_W];
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R10: idle bus reads zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    !bus_rd |-> (bus_rdata == '0));
  // R7: unmapped upper offsets read zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && bus_addr > OFF_WIN + ADDR_W'(BANK_LEN - 1)) |-> (bus_rdata == '0));
  // R9: pending byte upper bits are zero
  a_r9_pend_upper: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && bus_addr == OFF_PEND) |-> (bus_rdata[BYTE_W-1:BANK_LEN] == '0));
  // R4: control byte holds between writes
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_wr && bus_addr == OFF_CTRL) |=> $stable(ctrl_r));
endmodule

// File: tb/sim_gpio_paged_regs.sv
module sim_gpio_paged_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 43;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OOE = 2'd2;

  // {op, addr, data}: write / read-expect / pin_oe-byte-expect
  localparam logic [13:0] VEC [NV] = '{
    {OW,4'h7,8'h00},
    {OW,4'h0,8'h3C}, {OOE,4'h0,8'h3C},          // R2
    {OW,4'h5,8'h81}, {OOE,4'h5,8'h81},          // R2
    {ORD,4'h0,8'hA5}, {ORD,4'h1,8'h5A}, {ORD,4'h4,8'h00}, // R3
    {OW,4'h7,8'h40}, {ORD,4'h7,8'h40},          // R4
    {OW,4'h8,8'h11}, {OW,4'h9,8'h22}, {OW,4'hA,8'h33},
    {OW,4'h7,8'h80}, {OW,4'h8,8'h44}, {ORD,4'h8,8'h44}, {ORD,4'h9,8'h00}, // R6
    {OW,4'h7,8'hC0}, {OW,4'hA,8'h05}, {ORD,4'hA,8'h05}, {ORD,4'h6,8'h04}, // R6 R9
    {OW,4'h6,8'hFF}, {ORD,4'h6,8'h04},          // R9
    {OW,4'h7,8'h40}, {ORD,4'h8,8'h11}, {ORD,4'hA,8'h33}, {ORD,4'h6,8'h04}, // R6 R9
    {OW,4'h7,8'h00}, {ORD,4'h8,8'h00}, {OW,4'h9,8'hFF}, {ORD,4'hC,8'h00}, {ORD,4'hF,8'h00}, // R7
    {OW,4'h7,8'h40}, {ORD,4'h9,8'h22},          // R7
    {OW,4'h7,8'h41}, {OW,4'h0,8'hFF}, {OOE,4'h0,8'h3C}, // R5
    {OW,4'h1,8'h77}, {OOE,4'h1,8'h77}, {ORD,4'h7,8'h41}, // R8 R4
    {OW,4'h7,8'h00}, {OW,4'h0,8'hFF}, {OOE,4'h0,8'hFF}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_oe;
  logic [47:0] pin_in = 48'hFFFF_0000_A55A;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_paged_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .pin_in(pin_in)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(tag, {40'h0, bus_rdata}, {40'h0, exp});
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 pin_oe", pin_oe, 48'h0);
    rd(4'h7, 8'h00, "R1 ctrl");
    for (int p = 1; p < 4; p++) begin
      wr(4'h7, 8'(p << 6));
      for (int i = 8; i < 11; i++) rd(4'(i), 8'h00, "R1 bank");
    end
    wr(4'h7, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d;
      {op, a, d} = VEC[v];
      if (op == OW) wr(a, d);
      else if (op == ORD) rd(a, d, $sformatf("table row %0d read", v));
      else begin
        @(negedge clk);
        check($sformatf("table row %0d pin_oe", v), {40'h0, pin_oe[a*8 +: 8]}, {40'h0, d});
      end
    end

    // R10: rdata zero with read strobe low
    wr(4'h7, 8'hC0);
    @(negedge clk);
    bus_addr = 4'h7; bus_rd = 1'b0;
    #1 check("R10 idle", {40'h0, bus_rdata}, 48'h0);

    // R3: two-edge synchronizer latency
    @(negedge clk);
    pin_in[31:24] = 8'h0F; bus_addr = 4'h3; bus_rd = 1'b1;
    #1 check("R3 before edge", {40'h0, bus_rdata}, 48'hFF);
    @(negedge clk);
    #1 check("R3 after one edge", {40'h0, bus_rdata}, 48'hFF);
    @(negedge clk);
    #1 check("R3 after two edges", {40'h0, bus_rdata}, 48'hF0);
    bus_rd = 1'b0;

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async clear", pin_oe, 48'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h7, 8'h00, "R1 ctrl after reset");
    wr(4'h7, 8'h40);
    rd(4'h8, 8'h00, "R1 polarity after reset");
    wr(4'h7, 8'hC0);
    rd(4'hA, 8'h00, "R1 ident after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule